// File: doc/BRIEF.md
# SHA-512 Half-Word Sigma/Sum Unit

This functional unit sits in the execute stage of a 32-bit core. It runs six scalar instructions that help compute SHA-512. Each instruction reads two 32-bit source operands and joins them into one 64-bit word, with the first source as the low half and the second source as the high half. It then evaluates one of the SHA-512 Sum or sigma functions on that word. The result is the low 32 bits of that 64-bit function.

The datapath is purely combinational. One output register returns the result one cycle after issue, and the unit accepts a new instruction on every cycle. The unit also checks the instruction word and an enable input that says whether the hash extension is present. When the word is not one of its own encodings, or when the extension is absent, the unit flags the instruction as illegal and returns zero.

Top module: `sha512h_unit`

## Requirements
- R1: An instruction is legal only when all four of these hold: `en_i` is high, `instr_i[6:0]` is 7'b0110011, `instr_i[14:12]` is 3'b000, and `instr_i[31:25]` is one of the six operation codes. The codes are 0101000 sum0r, 0101001 sum1r, 0101010 sig0l, 0101110 sig0h, 0101011 sig1l and 0101111 sig1h. Bits [24:15] and [11:7] have no effect on the result.
- R2: The operand is X = {src_b_i, src_a_i}, so `src_a_i` is the low half. The result is bits [31:0] of the XOR of three 64-bit terms. When both sources are zero, every legal operation returns zero.
- R3: sum0r returns low32(rotl(X,25) ^ rotl(X,30) ^ rotr(X,28)).
- R4: sum1r returns low32(rotl(X,23) ^ rotr(X,14) ^ rotr(X,18)).
- R5: sig0l returns low32(rotr(X,1) ^ rotr(X,7) ^ rotr(X,8)).
- R6: sig1l returns low32(rotl(X,3) ^ rotr(X,6) ^ rotr(X,19)).
- R7: sig0h returns low32(rotr(X,1) ^ ({32'b0, src_a_i} >> 7) ^ rotr(X,8)).
- R8: sig1h returns low32(rotl(X,3) ^ ({32'b0, src_a_i} >> 6) ^ rotr(X,19)).
- R9: An issued instruction that is not legal under R1 sets `illegal_o` high with `result_o` equal to zero.
- R10: `valid_o` equals `valid_i` from the previous cycle. In a cycle with `valid_o` low, `result_o` is zero and `illegal_o` is low. The unit accepts an issue on every cycle without stalling.
- R11: While `rst_ni` is low, `valid_o`, `illegal_o` and `result_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Hash extension present |
| valid_i | input | 1 | Instruction issued this cycle |
| instr_i | input | 32 | Instruction word |
| src_a_i | input | XLEN | First source operand, low half of X |
| src_b_i | input | XLEN | Second source operand, high half of X |
| valid_o | output | 1 | Result valid, one cycle after issue |
| illegal_o | output | 1 | Issued instruction not owned or extension absent |
| result_o | output | XLEN | Low half of the selected function |

## Verification
Every result, illegal flag and valid bit is due exactly one clock edge after the cycle in which it was issued. The bench drives inputs on the falling edge and samples the outputs on the next falling edge, which is half a period after the only register has loaded. In the back-to-back scenario a new instruction goes in on every falling edge. At that same falling edge the bench checks the outputs of the instruction issued in the previous cycle, so the one-cycle spacing is confirmed under full throughput.

// File: rtl/sha512h_pkg.sv
package sha512h_pkg;
  localparam int NUM_OPS = 6;
  localparam logic [6:0] OPCODE_OP = 7'b0110011;
  localparam logic [2:0] FUNCT3_OP = 3'b000;

  typedef enum logic [2:0] {
    OP_SUM0R = 3'd0,
    OP_SUM1R = 3'd1,
    OP_SIG0L = 3'd2,
    OP_SIG0H = 3'd3,
    OP_SIG1L = 3'd4,
    OP_SIG1H = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    T_ROTR   = 2'd0,
    T_ROTL   = 2'd1,
    T_SHR_LO = 2'd2
  } term_kind_e;

  typedef struct packed {
    term_kind_e a_kind;
    logic [5:0] a_amt;
    term_kind_e b_kind;
    logic [5:0] b_amt;
    logic [5:0] c_amt;  // third term is always a right rotate
  } term_cfg_t;

  function automatic logic [6:0] funct7_of(int unsigned i);
    case (i)
      0:       return 7'b0101000;
      1:       return 7'b0101001;
      2:       return 7'b0101010;
      3:       return 7'b0101110;
      4:       return 7'b0101011;
      default: return 7'b0101111;
    endcase
  endfunction

  function automatic term_cfg_t cfg_of(int unsigned i);
    case (i)
      0:       return '{T_ROTL, 6'd25, T_ROTL,   6'd30, 6'd28};
      1:       return '{T_ROTL, 6'd23, T_ROTR,   6'd14, 6'd18};
      2:       return '{T_ROTR, 6'd1,  T_ROTR,   6'd7,  6'd8};
      3:       return '{T_ROTR, 6'd1,  T_SHR_LO, 6'd7,  6'd8};
      4:       return '{T_ROTL, 6'd3,  T_ROTR,   6'd6,  6'd19};
      default: return '{T_ROTL, 6'd3,  T_SHR_LO, 6'd6,  6'd19};
    endcase
  endfunction
endpackage

// File: rtl/sha512h_decode.sv
module sha512h_decode
  import sha512h_pkg::*;
(
  input  logic                en_i,
  input  logic [31:0]         instr_i,
  output logic [NUM_OPS-1:0]  sel_o,
  output logic                legal_o
);
  logic [NUM_OPS-1:0] f7_hit;
  logic               base_hit;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_hit
    assign f7_hit[g] = (instr_i[31:25] == funct7_of(g));
  end

  assign base_hit = (instr_i[6:0] == OPCODE_OP) && (instr_i[14:12] == FUNCT3_OP);
  assign legal_o  = en_i && base_hit && (|f7_hit);
  assign sel_o    = legal_o ? f7_hit : '0;
endmodule

// File: rtl/sha512h_lane.sv
module sha512h_lane
  import sha512h_pkg::*;
#(
  parameter int        XLEN = 32,
  parameter term_cfg_t CFG  = cfg_of(0)
) (
  input  logic [XLEN-1:0] src_a_i,
  input  logic [XLEN-1:0] src_b_i,
  output logic [XLEN-1:0] res_o
);
  localparam int DW = 2 * XLEN;

  function automatic logic [DW-1:0] rotr(logic [DW-1:0] v, int n);
    return (n == 0) ? v : ((v >> n) | (v << (DW - n)));
  endfunction

  function automatic logic [DW-1:0] rotl(logic [DW-1:0] v, int n);
    return (n == 0) ? v : ((v << n) | (v >> (DW - n)));
  endfunction

  function automatic logic [DW-1:0] term(term_kind_e k, logic [DW-1:0] v,
                                         logic [DW-1:0] lo, int n);
    case (k)
      T_ROTL:   return rotl(v, n);
      T_SHR_LO: return lo >> n;
      default:  return rotr(v, n);
    endcase
  endfunction

  logic [DW-1:0] x, lo_only, t_a, t_b, t_c, mix;

  always_comb begin
    x       = {src_b_i, src_a_i};
    lo_only = {{XLEN{1'b0}}, src_a_i};
    t_a     = term(CFG.a_kind, x, lo_only, int'(CFG.a_amt));
    t_b     = term(CFG.b_kind, x, lo_only, int'(CFG.b_amt));
    t_c     = rotr(x, int'(CFG.c_amt));
    mix     = t_a ^ t_b ^ t_c;
    res_o   = mix[XLEN-1:0];
  end
endmodule

// File: rtl/sha512h_datapath.sv
module sha512h_datapath
  import sha512h_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [NUM_OPS-1:0] sel_i,
  input  logic [XLEN-1:0]    src_a_i,
  input  logic [XLEN-1:0]    src_b_i,
  output logic [XLEN-1:0]    res_o
);
  logic [XLEN-1:0] lane_res [NUM_OPS];

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_lane
    sha512h_lane #(
      .XLEN (XLEN),
      .CFG  (cfg_of(g))
    ) lane_i (
      .src_a_i (src_a_i),
      .src_b_i (src_b_i),
      .res_o   (lane_res[g])
    );
  end

  // AND-OR mux; zero when nothing selected
  always_comb begin
    res_o = '0;
    for (int i = 0; i < NUM_OPS; i++) begin
      res_o |= lane_res[i] & {XLEN{sel_i[i]}};
    end
  end
endmodule

// File: rtl/sha512h_unit.sv
module sha512h_unit
  import sha512h_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            valid_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] src_a_i,
  input  logic [XLEN-1:0] src_b_i,
  output logic            valid_o,
  output logic            illegal_o,
  output logic [XLEN-1:0] result_o
);
  logic [NUM_OPS-1:0] sel;
  logic               legal;
  logic [XLEN-1:0]    res_d;

  sha512h_decode dec_i (
    .en_i    (en_i),
    .instr_i (instr_i),
    .sel_o   (sel),
    .legal_o (legal)
  );

  sha512h_datapath #(.XLEN(XLEN)) dp_i (
    .sel_i   (sel),
    .src_a_i (src_a_i),
    .src_b_i (src_b_i),
    .res_o   (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
      result_o  <= '0;
    end else begin
      valid_o   <= valid_i;
      illegal_o <= valid_i && !legal;
      result_o  <= valid_i ? res_d : '0;
    end
  end
endmodule

// File: rtl/sha512h_unit_chk.sv
module sha512h_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            en_i,
  input logic            valid_i,
  input logic [31:0]     instr_i,
  input logic [XLEN-1:0] src_a_i,
  input logic [XLEN-1:0] src_b_i,
  input logic            valid_o,
  input logic            illegal_o,
  input logic [XLEN-1:0] result_o
);
  // R10
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R10
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (result_o == '0) && !illegal_o);
  // R9
  illegal_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> result_o == '0);
  // R1
  disabled_illegal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !en_i) |=> illegal_o);
  // R1
  foreign_opcode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[6:0] != 7'b0110011) |=> illegal_o);
  // R2
  zero_operand_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && src_a_i == '0 && src_b_i == '0) |=> result_o == '0);
  // R11
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_state_chk: assert (!valid_o && !illegal_o && result_o == '0);
    end
  end
endmodule

bind sha512h_unit sha512h_unit_chk #(.XLEN(XLEN)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .valid_i   (valid_i),
  .instr_i   (instr_i),
  .src_a_i   (src_a_i),
  .src_b_i   (src_b_i),
  .valid_o   (valid_o),
  .illegal_o (illegal_o),
  .result_o  (result_o)
);

// File: tb/sha512h_unit_tb_top.sv
module sha512h_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] src_a_i = '0;
  logic [31:0] src_b_i = '0;
  logic        valid_o;
  logic        illegal_o;
  logic [31:0] result_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5ns clk_i = ~clk_i;

  sha512h_unit dut_i (
    .clk_i, .rst_ni, .en_i, .valid_i, .instr_i,
    .src_a_i, .src_b_i, .valid_o, .illegal_o, .result_o
  );

  // funct7 codes in op order sum0r, sum1r, sig0l, sig0h, sig1l, sig1h (R1)
  function automatic logic [6:0] f7(int op);
    case (op)
      0: return 7'b0101000;
      1: return 7'b0101001;
      2: return 7'b0101010;
      3: return 7'b0101110;
      4: return 7'b0101011;
      default: return 7'b0101111;
    endcase
  endfunction

  function automatic string req_of(int op);
    case (op)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R7";
      4: return "R6";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [63:0] rr(logic [63:0] v, int n);
    logic [127:0] d = {v, v} >> n;
    return d[63:0];
  endfunction

  function automatic logic [63:0] rl(logic [63:0] v, int n);
    logic [127:0] d = {v, v} << n;
    return d[127:64];
  endfunction

  function automatic logic [31:0] model(int op, logic [31:0] a, logic [31:0] b);
    logic [63:0] x = {b, a};
    logic [63:0] lo = {32'h0, a};
    logic [63:0] r;
    case (op)
      0: r = rl(x, 25) ^ rl(x, 30) ^ rr(x, 28);
      1: r = rl(x, 23) ^ rr(x, 14) ^ rr(x, 18);
      2: r = rr(x, 1) ^ rr(x, 7) ^ rr(x, 8);
      3: r = rr(x, 1) ^ (lo >> 7) ^ rr(x, 8);
      4: r = rl(x, 3) ^ rr(x, 6) ^ rr(x, 19);
      default: r = rl(x, 3) ^ (lo >> 6) ^ rr(x, 19);
    endcase
    return r[31:0];
  endfunction

  function automatic logic [31:0] mk(logic [6:0] fn7, logic [2:0] fn3,
                                     logic [6:0] opc, logic [14:0] rest);
    return {fn7, rest[14:5], fn3, rest[4:0], opc};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive at falling edge, sample at the next falling edge (one register)
  task automatic issue_chk(string req, logic en, logic [31:0] ins,
                           logic [31:0] a, logic [31:0] b,
                           logic exp_ill, logic [31:0] exp_res);
    @(negedge clk_i);
    en_i = en; valid_i = 1'b1; instr_i = ins; src_a_i = a; src_b_i = b;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk(req, "valid", {31'h0, valid_o}, 32'h1);
    chk(req, "illegal", {31'h0, illegal_o}, {31'h0, exp_ill});
    chk(req, "result", result_o, exp_res);
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    #1ns;
    chk("R11", "valid", {31'h0, valid_o}, 32'h0);
    chk("R11", "illegal", {31'h0, illegal_o}, 32'h0);
    chk("R11", "result", result_o, 32'h0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_corners;
    logic [31:0] pa [6] = '{32'h0, 32'hffffffff, 32'h1, 32'h0, 32'h8000_0000, 32'h1234_5678};
    logic [31:0] pb [6] = '{32'h0, 32'hffffffff, 32'h0, 32'h1, 32'h0, 32'h0};
    for (int op = 0; op < 6; op++) begin
      for (int p = 0; p < 6; p++) begin
        issue_chk(req_of(op), 1'b1, mk(f7(op), 3'b000, 7'b0110011, 15'h0),
                  pa[p], pb[p], 1'b0, model(op, pa[p], pb[p]));
      end
      // rs1 = 0 with random high half
      begin
        logic [31:0] b = $urandom;
        issue_chk(req_of(op), 1'b1, mk(f7(op), 3'b000, 7'b0110011, 15'h0),
                  32'h0, b, 1'b0, model(op, 32'h0, b));
      end
    end
    // R2: zero operands give zero on every op
    for (int op = 0; op < 6; op++)
      issue_chk("R2", 1'b1, mk(f7(op), 3'b000, 7'b0110011, 15'h7fff),
                32'h0, 32'h0, 1'b0, 32'h0);
  endtask

  task automatic t_random;
    for (int op = 0; op < 6; op++) begin
      for (int n = 0; n < 40; n++) begin
        logic [31:0] a = $urandom;
        logic [31:0] b = $urandom;
        logic [14:0] rest = 15'($urandom);  // R1: register fields ignored
        issue_chk(req_of(op), 1'b1, mk(f7(op), 3'b000, 7'b0110011, rest),
                  a, b, 1'b0, model(op, a, b));
      end
    end
  endtask

  task automatic t_illegal;
    logic [31:0] a = 32'hdead_beef;
    logic [31:0] b = 32'hcafe_f00d;
    // extension absent (R9)
    for (int op = 0; op < 6; op++)
      issue_chk("R9", 1'b0, mk(f7(op), 3'b000, 7'b0110011, 15'h0), a, b, 1'b1, 32'h0);
    // wrong opcode, wrong funct3, unowned funct7 (R1)
    issue_chk("R1", 1'b1, mk(f7(0), 3'b000, 7'b0010011, 15'h0), a, b, 1'b1, 32'h0);
    issue_chk("R1", 1'b1, mk(f7(2), 3'b001, 7'b0110011, 15'h0), a, b, 1'b1, 32'h0);
    issue_chk("R1", 1'b1, mk(7'b0101100, 3'b000, 7'b0110011, 15'h0), a, b, 1'b1, 32'h0);
    issue_chk("R1", 1'b1, mk(7'b0000000, 3'b000, 7'b0110011, 15'h0), a, b, 1'b1, 32'h0);
    issue_chk("R1", 1'b1, mk(7'b0101101, 3'b000, 7'b0110011, 15'h0), a, b, 1'b1, 32'h0);
  endtask

  task automatic t_idle;
    @(negedge clk_i);
    en_i = 1'b1; valid_i = 1'b0; instr_i = mk(f7(1), 3'b000, 7'b0110011, 15'h0);
    src_a_i = 32'h5555_aaaa; src_b_i = 32'h0f0f_f0f0;
    @(negedge clk_i);
    chk("R10", "idle valid", {31'h0, valid_o}, 32'h0);
    chk("R10", "idle illegal", {31'h0, illegal_o}, 32'h0);
    chk("R10", "idle result", result_o, 32'h0);
  endtask

  task automatic t_back_to_back;
    logic [31:0] exp_prev = '0;
    for (int n = 0; n < 24; n++) begin
      logic [31:0] a = $urandom;
      logic [31:0] b = $urandom;
      int op = n % 6;
      @(negedge clk_i);
      if (n > 0) begin
        chk("R10", "b2b valid", {31'h0, valid_o}, 32'h1);
        chk("R10", "b2b result", result_o, exp_prev);
      end
      en_i = 1'b1; valid_i = 1'b1;
      instr_i = mk(f7(op), 3'b000, 7'b0110011, 15'($urandom));
      src_a_i = a; src_b_i = b;
      exp_prev = model(op, a, b);
    end
    @(negedge clk_i);
    valid_i = 1'b0;
    chk("R10", "b2b last", result_o, exp_prev);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #2ms;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    t_reset();
    t_idle();
    t_corners();
    t_random();
    t_illegal();
    t_back_to_back();
    t_idle();
    done = 1'b1;
    finish_run();
  end
endmodule